// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block decides when a chip leaves its low-power standby state, and in what order its clocks return. When a standby request arrives while the chip is running, the block turns off every clock enable. It also stores the wake edge polarity and the stabilization period chosen at that moment. While in standby it watches a synchronized copy of the NMI pin. Only the polarity that was stored counts as a wake event. All other activity is ignored.

A valid NMI edge starts the wake sequence. First, only the watchdog counter's clock is enabled. The watchdog counts ticks in which the oscillator reports itself valid. When it overflows, the oscillator is taken to be stable. The block then enables the full-chip clock and holds a one-cycle state in which it requests NMI exception processing. After that it returns to the running state. Driving the power-on reset pin low bypasses the whole sequence. The block returns to the running state at once, with no clock edge needed.

Top module: `stby_wake_seq`

## Requirements
- R1: While rst_n is low, state_o reads 0 (RUN), chip_clk_en and wdt_clk_en are 1, and nmi_exc_req is 0.
- R2: In RUN, a clock edge with stby_req high moves state_o to 1 (STANDBY), where chip_clk_en and wdt_clk_en are both 0. That edge stores nmi_rise_sel and per_sel. Later changes on those inputs have no effect until the next entry.
- R3: In STANDBY, only an NMI edge of the stored polarity leaves the state: rising when nmi_rise_sel was 1, falling when it was 0. An edge of the other polarity and a stby_req pulse leave the state at 1.
- R4: nmi_pin passes through a two-stage synchronizer. After a valid wake change on the pin, state_o reads 2 (STABILIZE) from the third rising clock edge after the change, and still reads 1 after the second.
- R5: In STABILIZE, wdt_clk_en is 1 and chip_clk_en is 0.
- R6: STABILIZE ends after exactly 2^(6+2·S) clock edges in that state during which osc_valid is high, where S is the stored per_sel. Edges with osc_valid low do not count.
- R7: At overflow, state_o reads 3 (WAKE) for exactly one cycle, with chip_clk_en, wdt_clk_en and nmi_exc_req all 1. The next cycle is RUN with nmi_exc_req 0. nmi_exc_req is 1 in no other state.
- R8: Pulling rst_n low while in STANDBY or STABILIZE gives state_o 0 and chip_clk_en 1 at once, with no clock edge.
- R9: NMI edges whose synchronized transition ends before standby entry have no effect. The block stays in STANDBY until a new valid edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst_n | input | 1 | Power-on reset pin, active low, asynchronous |
| stby_req | input | 1 | Request to enter standby |
| nmi_pin | input | 1 | Raw NMI pin level |
| nmi_rise_sel | input | 1 | Wake edge polarity: 1 rising, 0 falling |
| per_sel | input | 3 | Stabilization period select S |
| osc_valid | input | 1 | Raw oscillator-valid tick qualifier |
| wdt_clk_en | output | 1 | Watchdog counter clock enable |
| chip_clk_en | output | 1 | Full-chip clock enable |
| nmi_exc_req | output | 1 | NMI exception request pulse |
| state_o | output | 2 | State: 0 RUN, 1 STANDBY, 2 STABILIZE, 3 WAKE |

## Verification
The wake sequence is exercised with both edge polarities and with period selects 0 to 4. The live polarity and period inputs are inverted after entry, so a design that reads them live instead of stored picks the wrong edge or a much longer period. One case toggles osc_valid on every cycle, which separates counting qualified ticks from counting raw cycles. Directed cases apply the opposite edge, stby_req pulses, and edges made while running, none of which may wake the block. They also apply reset in standby and during stabilization, which must act without waiting for a clock edge.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STBY = 2'd1,
        ST_STAB = 2'd2,
        ST_WAKE = 2'd3
    } wk_state_e;

    typedef struct packed {
        logic             rise_sel;
        logic [SEL_W-1:0] per_sel;
    } wk_cfg_t;

endpackage

// File: rtl/stby_nmi_edge.sv
module stby_nmi_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic rise_sel,
    output logic edge_hit
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], nmi_pin};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        lvl       = st_q.sync[SYNC_STAGES-1];
        edge_hit  = rise_sel ? (lvl & ~st_q.prev) : (~lvl & st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer
    import stby_wake_pkg::*;
#(
    parameter int BASE_EXP = 6,
    parameter int STEP_EXP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf
);
    localparam int NSEL    = 1 << SEL_W;
    localparam int MAX_EXP = BASE_EXP + STEP_EXP * (NSEL - 1);
    localparam int CNT_W   = MAX_EXP;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t          st_d, st_q;
    logic [CNT_W-1:0] term [NSEL];
    logic             hit;

    for (genvar g = 0; g < NSEL; g++) begin : g_term
        assign term[g] = CNT_W'((64'd1 << (BASE_EXP + STEP_EXP * g)) - 64'd1);
    end

    always_comb begin
        st_d = st_q;
        hit  = run && tick && (st_q.cnt == term[sel]);
        if (!run)      st_d.cnt = '0;
        else if (hit)  st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        ovf = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/stby_wake_fsm.sv
module stby_wake_fsm
    import stby_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stby_req,
    input  wk_cfg_t   cfg_in,
    input  logic      edge_hit,
    input  logic      ovf,
    output wk_state_e state,
    output wk_cfg_t   cfg
);
    typedef struct packed {
        wk_state_e st;
        wk_cfg_t   cfg;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            ST_RUN: begin
                if (stby_req) begin
                    st_d.st  = ST_STBY;
                    st_d.cfg = cfg_in;
                end
            end
            ST_STBY: begin
                if (edge_hit) st_d.st = ST_STAB;
            end
            ST_STAB: begin
                if (ovf) st_d.st = ST_WAKE;
            end
            ST_WAKE: begin
                st_d.st = ST_RUN;
            end
            default: st_d.st = ST_RUN;
        endcase
        state = st_q.st;
        cfg   = st_q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st  <= ST_RUN;
            st_q.cfg <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stby_wake_seq.sv
module stby_wake_seq
    import stby_wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_EXP    = 6,
    parameter int STEP_EXP    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_req,
    input  logic             nmi_pin,
    input  logic             nmi_rise_sel,
    input  logic [SEL_W-1:0] per_sel,
    input  logic             osc_valid,
    output logic             wdt_clk_en,
    output logic             chip_clk_en,
    output logic             nmi_exc_req,
    output logic [1:0]       state_o
);
    wk_cfg_t   cfg_in;
    wk_cfg_t   cfg;
    wk_state_e state;
    logic      edge_hit;
    logic      ovf;

    assign cfg_in.rise_sel = nmi_rise_sel;
    assign cfg_in.per_sel  = per_sel;

    stby_nmi_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_pin  (nmi_pin),
        .rise_sel (cfg.rise_sel),
        .edge_hit (edge_hit)
    );

    stby_stab_timer #(
        .BASE_EXP(BASE_EXP),
        .STEP_EXP(STEP_EXP)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_STAB),
        .tick  (osc_valid),
        .sel   (cfg.per_sel),
        .ovf   (ovf)
    );

    stby_wake_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stby_req (stby_req),
        .cfg_in   (cfg_in),
        .edge_hit (edge_hit),
        .ovf      (ovf),
        .state    (state),
        .cfg      (cfg)
    );

    always_comb begin
        chip_clk_en = (state == ST_RUN) || (state == ST_WAKE);
        wdt_clk_en  = (state != ST_STBY);
        nmi_exc_req = (state == ST_WAKE);
        state_o     = state;
    end
endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stby_req,
    input logic       osc_valid,
    input logic       nmi_exc_req,
    input logic       chip_clk_en,
    input logic [1:0] state_o
);
    // R2
    run_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && stby_req) |=> state_o == 2'd1);

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && !stby_req) |=> state_o == 2'd0);

    // R3
    stby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd1 |=> (state_o == 2'd1 || state_o == 2'd2));

    // R6
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && !osc_valid) |=> state_o == 2'd2);

    // R7
    wake_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd3 |=> state_o == 2'd0);

    // R7
    exc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_exc_req) |-> $past(state_o) == 2'd2);

    // R7
    chip_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_clk_en) |-> $past(state_o) == 2'd2);
endmodule

bind stby_wake_seq stby_wake_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stby_req    (stby_req),
    .osc_valid   (osc_valid),
    .nmi_exc_req (nmi_exc_req),
    .chip_clk_en (chip_clk_en),
    .state_o     (state_o)
);

// File: tb/sim_stby_wake_seq.sv
module sim_stby_wake_seq;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_req = 1'b0;
    logic       nmi_pin = 1'b1;
    logic       nmi_rise_sel = 1'b0;
    logic [2:0] per_sel = 3'd0;
    logic       osc_valid = 1'b1;
    logic       wdt_clk_en, chip_clk_en, nmi_exc_req;
    logic [1:0] state_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // {rise, sel[2:0], half-rate osc_valid, expected qualified ticks}
    localparam logic [36:0] VEC [7] = '{
        {1'b0, 3'd0, 1'b0, 32'd64},
        {1'b1, 3'd0, 1'b0, 32'd64},
        {1'b1, 3'd1, 1'b0, 32'd256},
        {1'b0, 3'd2, 1'b0, 32'd1024},
        {1'b1, 3'd3, 1'b0, 32'd4096},
        {1'b0, 3'd1, 1'b1, 32'd256},
        {1'b1, 3'd4, 1'b0, 32'd16384}
    };

    stby_wake_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .stby_req     (stby_req),
        .nmi_pin      (nmi_pin),
        .nmi_rise_sel (nmi_rise_sel),
        .per_sel      (per_sel),
        .osc_valid    (osc_valid),
        .wdt_clk_en   (wdt_clk_en),
        .chip_clk_en  (chip_clk_en),
        .nmi_exc_req  (nmi_exc_req),
        .state_o      (state_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic enter_standby();
        stby_req = 1'b1;
        @(negedge clk);
        stby_req = 1'b0;
    endtask

    task automatic run_wake(input logic rise, input logic [2:0] sel,
                            input logic half, input logic [31:0] exp);
        int ticks = 0;
        int guard = 0;
        nmi_rise_sel = rise;
        per_sel      = sel;
        nmi_pin      = ~rise;
        repeat (4) @(negedge clk);
        enter_standby();
        chk("R2 state", 32'(state_o), 32'd1);
        chk("R2 chip_en", 32'(chip_clk_en), 32'd0);
        chk("R2 wdt_en", 32'(wdt_clk_en), 32'd0);
        nmi_rise_sel = ~rise;
        per_sel      = ~sel;
        repeat (5) @(negedge clk);
        chk("R3 hold", 32'(state_o), 32'd1);
        nmi_pin = rise;
        repeat (2) @(negedge clk);
        chk("R4 after two edges", 32'(state_o), 32'd1);
        @(negedge clk);
        chk("R4 after three edges", 32'(state_o), 32'd2);
        chk("R5 wdt_en", 32'(wdt_clk_en), 32'd1);
        chk("R5 chip_en", 32'(chip_clk_en), 32'd0);
        while (state_o == 2'd2 && guard < 40000) begin
            osc_valid = half ? ~osc_valid : 1'b1;
            if (osc_valid) ticks++;
            @(negedge clk);
            guard++;
        end
        chk("R6 ticks", 32'(ticks), exp);
        chk("R7 wake state", 32'(state_o), 32'd3);
        chk("R7 exc_req", 32'(nmi_exc_req), 32'd1);
        chk("R7 chip_en", 32'(chip_clk_en), 32'd1);
        @(negedge clk);
        chk("R7 back to run", 32'(state_o), 32'd0);
        chk("R7 exc_req low", 32'(nmi_exc_req), 32'd0);
        osc_valid = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        chk("R1 state", 32'(state_o), 32'd0);
        chk("R1 chip_en", 32'(chip_clk_en), 32'd1);
        chk("R1 wdt_en", 32'(wdt_clk_en), 32'd1);
        chk("R1 exc_req", 32'(nmi_exc_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 7; i++)
            run_wake(VEC[i][36], VEC[i][35:33], VEC[i][32], VEC[i][31:0]);

        // R9: edges while running, then standby with no fresh edge
        nmi_rise_sel = 1'b1;
        nmi_pin = 1'b0;
        repeat (3) @(negedge clk);
        nmi_pin = 1'b1;
        repeat (3) @(negedge clk);
        nmi_pin = 1'b0;
        repeat (3) @(negedge clk);
        nmi_pin = 1'b1;
        repeat (4) @(negedge clk);
        enter_standby();
        repeat (30) @(negedge clk);
        chk("R9 no wake from old edges", 32'(state_o), 32'd1);
        // R8: reset in standby acts without a clock edge
        #1 rst_n = 1'b0;
        #1;
        chk("R8 standby reset state", 32'(state_o), 32'd0);
        chk("R8 standby reset chip_en", 32'(chip_clk_en), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: opposite edge and stby_req pulses are ignored in standby
        nmi_rise_sel = 1'b0;
        per_sel = 3'd2;
        nmi_pin = 1'b0;
        repeat (4) @(negedge clk);
        enter_standby();
        nmi_pin = 1'b1;
        repeat (3) @(negedge clk);
        stby_req = 1'b1;
        repeat (4) @(negedge clk);
        stby_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 opposite edge ignored", 32'(state_o), 32'd1);
        nmi_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 valid edge after ignored one", 32'(state_o), 32'd2);
        repeat (20) @(negedge clk);
        chk("R6 still stabilizing", 32'(state_o), 32'd2);
        // R8: reset during stabilization
        #1 rst_n = 1'b0;
        #1;
        chk("R8 stabilize reset state", 32'(state_o), 32'd0);
        chk("R8 stabilize reset chip_en", 32'(chip_clk_en), 32'd1);
        chk("R1 exc_req in reset", 32'(nmi_exc_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 stays running", 32'(state_o), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule